// File: doc/BRIEF.md
# Maskable sticky interrupt aggregator

This block gathers a parameterised number of event conditions into one interrupt line. Each condition is sampled every clock. The block keeps a registered copy of it, and a rising edge sets a sticky status bit for that source. Every source has its own mask bit. A set status bit whose source is unmasked and has not yet been read drives the interrupt output.

Software learns about events through a status read strobe. A read returns the whole status word on a registered data output and acts as a read-to-clear. A bit is cleared only if its condition is low at the time of the read. A bit whose condition is still high stays set, but it no longer counts toward the interrupt. It will request service again only after that source produces a fresh rising edge. The mask word is written as a whole through a single write strobe.

The interrupt output is registered. It changes on the same clock edge that updates the status, the pending state or the mask.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every status bit reads as 0, every mask bit is 1 (masked) and the interrupt output is 0.
- R2: A rising edge on a condition input sets its status bit on the clock edge that samples the condition high. Holding the condition high produces no further edge.
- R3: A rising edge on an unmasked source drives the interrupt output to 1 on that same clock edge.
- R4: A rising edge on a masked source sets its status bit but leaves the interrupt output unchanged.
- R5: A status read places the status word as it stood before the read on the read data output, from the clock edge of the read. A status bit changes from 1 to 0 only on a read, and only when its condition is low during that read.
- R6: When a read meets a condition that is still high, that status bit stays set and the interrupt output drops to 0, provided no other unmasked event is pending.
- R7: After such a read, the interrupt output asserts again only when that source falls and then rises again.
- R8: A rising edge that arrives in the same cycle as a read leaves that bit set and pending, so the interrupt output is 1 after the read.
- R9: Unmasking a source whose status bit is set and has not been read asserts the interrupt output. Masking it again deasserts the output. Mask bit i (1 = masked) belongs to source i.
- R10: Once asserted, the interrupt output stays at 1 while further events arrive, until a status read covers every pending unmasked bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | SRC | Event condition levels, one bit per source, synchronous to clk |
| mask_wr_i | input | 1 | Writes mask_wdata_i into the mask word |
| mask_wdata_i | input | SRC | New mask word, bit i = 1 masks source i |
| stat_rd_i | input | 1 | Status read strobe, performs read-to-clear |
| stat_rdata_o | output | SRC | Status word captured by the last read |
| irq_o | output | 1 | Registered interrupt request, active high |

## Verification
On every cycle, the assertions check four rules. A detected edge always sets its status bit. No status bit clears without a read. The pending set is always a subset of the status bits. The interrupt output always equals the OR of pending, unmasked sources. The assertions also check that a read with no coincident edge or mask write drops the interrupt, and that an edge coinciding with a read stays pending. Some behaviours need the bench's directed scenarios, because they depend on a sequence of stimulus across several reads. These are a persistent condition that survives a read and re-arms only after falling and rising again, the reset value of the mask seen through a suppressed interrupt, late unmasking of an unread bit, and the exact word a read returns.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  parameter int unsigned SRC_DEFAULT = 16;
  typedef enum logic [1:0] {
    UPD_HOLD  = 2'd0,
    UPD_READ  = 2'd1
  } upd_kind_e;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int unsigned SRC = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [SRC-1:0] cond_i,
  output logic [SRC-1:0] rise_o
);
  logic [SRC-1:0] cond_q;

  for (genvar g = 0; g < SRC; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) cond_q[g] <= 1'b0;
      else     cond_q[g] <= cond_i[g];
    end
    assign rise_o[g] = cond_i[g] & ~cond_q[g];
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_agg_pkg::*;
#(
  parameter int unsigned SRC = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [SRC-1:0] rise_i,
  input  logic [SRC-1:0] cond_i,
  input  logic           rd_i,
  output logic [SRC-1:0] status_q,
  output logic [SRC-1:0] pend_q,
  output logic [SRC-1:0] pend_d
);
  upd_kind_e      kind;
  logic [SRC-1:0] status_d;

  assign kind = rd_i ? UPD_READ : UPD_HOLD;

  always_comb begin
    status_d = status_q | rise_i;
    pend_d   = pend_q | rise_i;
    if (kind == UPD_READ) begin
      status_d = rise_i | (status_q & cond_i);
      pend_d   = rise_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      pend_q   <= '0;
    end else begin
      status_q <= status_d;
      pend_q   <= pend_d;
    end
  end

  a_r2_rise_sets_status: assert property (@(posedge clk) disable iff (rst)
    (rise_i != '0) |=> ((status_q & $past(rise_i)) == $past(rise_i)));

  a_r5_no_clear_without_read: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> ((~status_q & $past(status_q)) == '0));

  a_r6_pending_within_status: assert property (@(posedge clk) disable iff (rst)
    ((pend_q & ~status_q) == '0));

  a_r8_rise_on_read_stays_pending: assert property (@(posedge clk) disable iff (rst)
    (rd_i && (rise_i != '0)) |=> ((pend_q & $past(rise_i)) == $past(rise_i)));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned SRC = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_i,
  input  logic [SRC-1:0] wdata_i,
  output logic [SRC-1:0] mask_q,
  output logic [SRC-1:0] mask_d
);
  assign mask_d = wr_i ? wdata_i : mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '1;
    else     mask_q <= mask_d;
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned SRC = SRC_DEFAULT
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [SRC-1:0] cond_i,
  input  logic           mask_wr_i,
  input  logic [SRC-1:0] mask_wdata_i,
  input  logic           stat_rd_i,
  output logic [SRC-1:0] stat_rdata_o,
  output logic           irq_o
);
  logic [SRC-1:0] rise;
  logic [SRC-1:0] status_q;
  logic [SRC-1:0] pend_q;
  logic [SRC-1:0] pend_d;
  logic [SRC-1:0] mask_q;
  logic [SRC-1:0] mask_d;
  logic           irq_q;
  logic [SRC-1:0] rdata_q;

  irq_edge_det #(.SRC(SRC)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .cond_i (cond_i),
    .rise_o (rise)
  );

  irq_status_bank #(.SRC(SRC)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .rise_i   (rise),
    .cond_i   (cond_i),
    .rd_i     (stat_rd_i),
    .status_q (status_q),
    .pend_q   (pend_q),
    .pend_d   (pend_d)
  );

  irq_mask_reg #(.SRC(SRC)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (mask_wr_i),
    .wdata_i (mask_wdata_i),
    .mask_q  (mask_q),
    .mask_d  (mask_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      irq_q <= |(pend_d & ~mask_d);
      if (stat_rd_i) rdata_q <= status_q;
    end
  end

  assign irq_o        = irq_q;
  assign stat_rdata_o = rdata_q;

  a_r9_irq_tracks_unmasked_pending: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(pend_q & ~mask_q));

  a_r6_read_drops_irq: assert property (@(posedge clk) disable iff (rst)
    (stat_rd_i && (rise == '0) && !mask_wr_i) |=> !irq_o);
endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  localparam int unsigned SRC = 8;
  localparam time CLK_PERIOD = 10ns;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [SRC-1:0] cond = '0;
  logic           mask_wr = 1'b0;
  logic [SRC-1:0] mask_wdata = '0;
  logic           stat_rd = 1'b0;
  logic [SRC-1:0] rdata;
  logic           irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_aggregator #(.SRC(SRC)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .cond_i       (cond),
    .mask_wr_i    (mask_wr),
    .mask_wdata_i (mask_wdata),
    .stat_rd_i    (stat_rd),
    .stat_rdata_o (rdata),
    .irq_o        (irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse(int b);
    cond[b] = 1'b1;
    tick();
    cond[b] = 1'b0;
  endtask

  task automatic do_read(output logic [SRC-1:0] d);
    stat_rd = 1'b1;
    tick();
    stat_rd = 1'b0;
    d = rdata;
  endtask

  task automatic write_mask(logic [SRC-1:0] m);
    mask_wr    = 1'b1;
    mask_wdata = m;
    tick();
    mask_wr = 1'b0;
  endtask

  task automatic t_reset();
    logic [SRC-1:0] d;
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    check("R1 irq after reset", irq, 0);
    do_read(d);
    check("R1 status after reset", d, 0);
  endtask

  task automatic t_masked_event();
    logic [SRC-1:0] d;
    pulse(0);
    check("R1 R4 masked edge leaves irq low", irq, 0);
    do_read(d);
    check("R4 R2 masked edge sets status", d, 8'h01);
    do_read(d);
    check("R5 bit cleared by read with condition low", d, 8'h00);
  endtask

  task automatic t_unmasked_events();
    logic [SRC-1:0] d;
    write_mask(8'h00);
    check("R9 unmask with nothing pending", irq, 0);
    pulse(1);
    check("R3 unmasked edge asserts irq", irq, 1);
    repeat (3) tick();
    pulse(2);
    check("R10 irq held through second event", irq, 1);
    do_read(d);
    check("R5 read returns both bits", d, 8'h06);
    check("R10 irq drops after covering read", irq, 0);
    do_read(d);
    check("R5 both bits cleared", d, 8'h00);
  endtask

  task automatic t_persistent();
    logic [SRC-1:0] d;
    cond[3] = 1'b1;
    tick();
    check("R3 persistent source asserts irq", irq, 1);
    do_read(d);
    check("R5 read sees persistent bit", d, 8'h08);
    check("R6 irq drops despite high condition", irq, 0);
    do_read(d);
    check("R6 bit stays set while condition high", d, 8'h08);
    repeat (4) tick();
    check("R7 no reassert while level held", irq, 0);
    cond[3] = 1'b0;
    tick();
    check("R7 falling edge does not assert", irq, 0);
    cond[3] = 1'b1;
    tick();
    check("R7 new rising edge reasserts", irq, 1);
    cond[3] = 1'b0;
    tick();
    do_read(d);
    check("R5 read after condition fell", d, 8'h08);
    do_read(d);
    check("R5 persistent bit finally cleared", d, 8'h00);
    check("R6 irq low after clear", irq, 0);
  endtask

  task automatic t_coincident();
    logic [SRC-1:0] d;
    cond[4] = 1'b1;
    stat_rd = 1'b1;
    tick();
    stat_rd = 1'b0;
    cond[4] = 1'b0;
    check("R8 irq set after edge during read", irq, 1);
    check("R8 read returns pre-edge word", rdata, 8'h00);
    do_read(d);
    check("R8 edge bit survived the read", d, 8'h10);
    check("R8 irq low after second read", irq, 0);
    do_read(d);
    check("R5 coincident bit cleared", d, 8'h00);
  endtask

  task automatic t_late_unmask();
    logic [SRC-1:0] d;
    write_mask(8'hFF);
    pulse(5);
    check("R4 masked edge, irq low", irq, 0);
    write_mask(8'hDF);
    check("R9 unmasking unread bit asserts irq", irq, 1);
    write_mask(8'hFF);
    check("R9 remasking drops irq", irq, 0);
    write_mask(8'h00);
    check("R9 unmask again asserts irq", irq, 1);
    do_read(d);
    check("R5 read returns bit 5", d, 8'h20);
    check("R10 irq low after read", irq, 0);
  endtask

  task automatic t_level_single_edge();
    logic [SRC-1:0] d;
    cond[6] = 1'b1;
    tick();
    do_read(d);
    check("R2 level sets bit once", d, 8'h40);
    repeat (3) tick();
    check("R2 held level gives no new edge", irq, 0);
    cond[6] = 1'b0;
    tick();
    do_read(d);
    do_read(d);
    check("R5 level bit cleared", d, 8'h00);
  endtask

  initial begin
    t_reset();
    t_masked_event();
    t_unmasked_events();
    t_persistent();
    t_coincident();
    t_late_unmask();
    t_level_single_edge();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule